// File: doc/BRIEF.md
# RV32I Immediate Operand Generator

This combinational unit takes a 32-bit base-integer instruction word and produces the immediate operand for that instruction. It classifies the word into one of the register, immediate, store, branch, upper or jump layouts using the 7-bit opcode. It then gathers the immediate bits that are spread across the word and sign-extends the result to the datapath width.

For shift-by-immediate operations, the unit also returns the shift amount and a flag that selects an arithmetic right shift. Opcodes it does not recognise give a zero immediate and raise an illegal-format flag. The block sits between instruction fetch and the operand multiplexers of an execute stage and adds no pipeline stage.

Top module: `rv_imm_gen`

## Requirements
- R1: Opcodes 0010011, 0000011 and 1100111 select the I layout (fmt_o = 1), and imm_o is instr_i[31:20] sign-extended.
- R2: Opcode 0100011 selects the S layout (fmt_o = 2), and imm_o is {instr_i[31:25], instr_i[11:7]} sign-extended.
- R3: Opcode 1100011 selects the B layout (fmt_o = 3), and imm_o is {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 0} sign-extended, so bit 0 of imm_o is always 0.
- R4: Opcodes 0110111 and 0010111 select the U layout (fmt_o = 4), and imm_o is {instr_i[31:12], 12'h000}.
- R5: Opcode 1101111 selects the J layout (fmt_o = 5), and imm_o is {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 0} sign-extended, so bit 0 of imm_o is always 0.
- R6: For every layout that carries an immediate, each bit of imm_o above the encoded field equals instr_i[31].
- R7: Opcode 0110011 is the register layout (fmt_o = 0). It gives imm_o = 0 and illegal_o = 0.
- R8: Any other opcode gives fmt_o = 7, illegal_o = 1, imm_o = 0, shamt_o = 0 and shift_arith_o = 0.
- R9: When the opcode is 0010011 and funct3 (instr_i[14:12]) is 001 or 101, shamt_o equals instr_i[24:20]. Otherwise shamt_o is 0.
- R10: shift_arith_o is 1 only when the opcode is 0010011, funct3 is 101 and instr_i[30] is 1. The same bit pattern under funct3 001 or under any other opcode leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| imm_o | output | XLEN | Sign-extended immediate operand |
| fmt_o | output | 3 | Layout code: 0 R, 1 I, 2 S, 3 B, 4 U, 5 J, 7 unknown |
| shamt_o | output | $clog2(XLEN) | Shift amount for shift-immediate operations |
| shift_arith_o | output | 1 | Selects an arithmetic right shift |
| illegal_o | output | 1 | Opcode not recognised |

## Verification
The block holds no state. A wrong opcode classification or a misrouted bit therefore appears on imm_o, fmt_o or the shift outputs in the same cycle the word is applied. The most telling cases are offsets with only the sign bit set or only the top magnitude bit set, and the branch and jump bit 11 paths. A one-wire swap in either of those paths leaves small offsets correct and corrupts only these values. The shift flag is checked against instructions that look the same but differ in funct3 or opcode, so a decode that is too loose shows up as a stray arithmetic select.

// File: rtl/rv_imm_pkg.sv
package rv_imm_pkg;
  typedef enum logic [2:0] {
    FMT_R    = 3'd0,
    FMT_I    = 3'd1,
    FMT_S    = 3'd2,
    FMT_B    = 3'd3,
    FMT_U    = 3'd4,
    FMT_J    = 3'd5,
    FMT_NONE = 3'd7
  } fmt_e;

  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_OP     = 7'b0110011;

  localparam logic [2:0] F3_SLL = 3'b001;
  localparam logic [2:0] F3_SR  = 3'b101;
endpackage

// File: rtl/imm_fmt_decode.sv
module imm_fmt_decode
  import rv_imm_pkg::*;
(
  input  logic [6:0] opcode_i,
  output fmt_e       fmt_o,
  output logic       illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    unique case (opcode_i)
      OPC_OPIMM, OPC_LOAD, OPC_JALR: fmt_o = FMT_I;
      OPC_STORE:                     fmt_o = FMT_S;
      OPC_BRANCH:                    fmt_o = FMT_B;
      OPC_LUI, OPC_AUIPC:            fmt_o = FMT_U;
      OPC_JAL:                       fmt_o = FMT_J;
      OPC_OP:                        fmt_o = FMT_R;
      default: begin
        fmt_o     = FMT_NONE;
        illegal_o = 1'b1;
      end
    endcase
  end

  // R8: the flag and the unknown code always travel together
  always_comb begin
    p_illegal_code_r8: assert (illegal_o == (fmt_o == FMT_NONE))
      else $error("illegal flag and format code disagree");
  end
endmodule

// File: rtl/imm_assemble.sv
module imm_assemble
  import rv_imm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:7]     instr_i,
  input  fmt_e            fmt_i,
  output logic [XLEN-1:0] imm_o
);
  localparam int ILEN = 32;
  localparam int EXT  = XLEN - ILEN;

  logic        sgn;
  logic [31:0] imm32;

  assign sgn = instr_i[31];

  always_comb begin
    unique case (fmt_i)
      FMT_I: imm32 = {{20{sgn}}, instr_i[31:20]};
      FMT_S: imm32 = {{20{sgn}}, instr_i[31:25], instr_i[11:7]};
      FMT_B: imm32 = {{19{sgn}}, instr_i[31], instr_i[7], instr_i[30:25],
                      instr_i[11:8], 1'b0};
      FMT_U: imm32 = {instr_i[31:12], 12'h000};
      FMT_J: imm32 = {{11{sgn}}, instr_i[31], instr_i[19:12], instr_i[20],
                      instr_i[30:21], 1'b0};
      default: imm32 = '0;
    endcase
  end

  // Widen to the datapath width when it exceeds the instruction width
  generate
    if (EXT > 0) begin : g_wide
      assign imm_o = {{EXT{imm32[31]}}, imm32};
    end else begin : g_native
      assign imm_o = imm32[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/imm_shift_extract.sv
module imm_shift_extract
  import rv_imm_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHAMT_W = $clog2(XLEN)
) (
  input  logic [6:0]         opcode_i,
  input  logic [2:0]         funct3_i,
  input  logic [SHAMT_W-1:0] shamt_field_i,
  input  logic               alt_i,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic               arith_o
);
  logic is_opimm;
  logic is_shift;

  assign is_opimm = (opcode_i == OPC_OPIMM);
  assign is_shift = is_opimm && (funct3_i == F3_SLL || funct3_i == F3_SR);
  assign shamt_o  = is_shift ? shamt_field_i : '0;
  assign arith_o  = is_opimm && (funct3_i == F3_SR) && alt_i;

  always_comb begin
    p_arith_right_only_r10: assert (!arith_o || (shamt_o == shamt_field_i && funct3_i == F3_SR))
      else $error("arithmetic select outside right shift");
    p_shamt_opimm_r9: assert (shamt_o == '0 || is_opimm)
      else $error("shift amount on non shift-immediate opcode");
  end
endmodule

// File: rtl/rv_imm_gen.sv
module rv_imm_gen
  import rv_imm_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHAMT_W = $clog2(XLEN)
) (
  input  logic [31:0]        instr_i,
  output logic [XLEN-1:0]    imm_o,
  output logic [2:0]         fmt_o,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic               shift_arith_o,
  output logic               illegal_o
);
  fmt_e fmt;

  imm_fmt_decode u_decode (
    .opcode_i  (instr_i[6:0]),
    .fmt_o     (fmt),
    .illegal_o (illegal_o)
  );

  imm_assemble #(.XLEN(XLEN)) u_assemble (
    .instr_i (instr_i[31:7]),
    .fmt_i   (fmt),
    .imm_o   (imm_o)
  );

  imm_shift_extract #(.XLEN(XLEN)) u_shift (
    .opcode_i      (instr_i[6:0]),
    .funct3_i      (instr_i[14:12]),
    .shamt_field_i (instr_i[20 +: SHAMT_W]),
    .alt_i         (instr_i[30]),
    .shamt_o       (shamt_o),
    .arith_o       (shift_arith_o)
  );

  assign fmt_o = fmt;

  always_comb begin
    p_bj_even_r3: assert (!(fmt == FMT_B || fmt == FMT_J) || imm_o[0] == 1'b0)
      else $error("branch or jump offset is odd");
    p_u_low_zero_r4: assert (fmt != FMT_U || imm_o[11:0] == 12'h000)
      else $error("upper immediate low bits not clear");
    p_sign_ext_r6: assert (fmt == FMT_R || fmt == FMT_NONE || imm_o[XLEN-1] == instr_i[31])
      else $error("immediate sign does not follow instruction bit 31");
    p_reg_zero_r7: assert (fmt != FMT_R || (imm_o == '0 && !illegal_o))
      else $error("register layout produced an immediate");
    p_illegal_quiet_r8: assert (!illegal_o || (imm_o == '0 && shamt_o == '0 && !shift_arith_o))
      else $error("unknown opcode drove a non-zero output");
  end
endmodule

// File: tb/rv_imm_gen_bench.sv
module rv_imm_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr = '0;
  logic [31:0] imm;
  logic [2:0]  fmt;
  logic [4:0]  shamt;
  logic        arith;
  logic        ill;

  rv_imm_gen u_rv_imm_gen (
    .instr_i       (instr),
    .imm_o         (imm),
    .fmt_o         (fmt),
    .shamt_o       (shamt),
    .shift_arith_o (arith),
    .illegal_o     (ill)
  );

  typedef struct {
    string       req;
    logic [31:0] instr;
    logic [31:0] imm;
    logic [2:0]  fmt;
    logic [4:0]  shamt;
    logic        arith;
    logic        ill;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Driver: apply the word on a rising edge, queue what must appear
  task automatic drive(string req, logic [31:0] ins, logic [31:0] e_imm, logic [2:0] e_fmt,
                       logic [4:0] e_sh, logic e_ar, logic e_il);
    item_t it;
    @(posedge clk);
    instr = ins;
    it.req = req; it.instr = ins; it.imm = e_imm; it.fmt = e_fmt;
    it.shamt = e_sh; it.arith = e_ar; it.ill = e_il;
    q.push_back(it);
  endtask

  // Monitor: compare half a cycle after the word is applied
  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (imm !== it.imm || fmt !== it.fmt || shamt !== it.shamt ||
          arith !== it.arith || ill !== it.ill) begin
        errors++;
        $display("FAIL %s instr=%h got imm=%h fmt=%0d sh=%0d ar=%b il=%b exp imm=%h fmt=%0d sh=%0d ar=%b il=%b",
                 it.req, it.instr, imm, fmt, shamt, arith, ill,
                 it.imm, it.fmt, it.shamt, it.arith, it.ill);
      end
    end
  end

  function automatic logic [31:0] enc_i(logic [6:0] opc, logic [2:0] f3, logic [11:0] v);
    return {v, 5'd3, f3, 5'd7, opc};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] v);
    return {v[11:5], 5'd4, 5'd5, 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] off);
    return {off[12], off[10:5], 5'd6, 5'd7, 3'b001, off[4:1], off[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_u(logic [6:0] opc, logic [19:0] up);
    return {up, 5'd9, opc};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
  endfunction
  function automatic logic [31:0] sx12(logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction
  function automatic logic [31:0] sx13(logic [12:0] v);
    return {{19{v[12]}}, v[12:1], 1'b0};
  endfunction
  function automatic logic [31:0] sx21(logic [20:0] v);
    return {{11{v[20]}}, v[20:1], 1'b0};
  endfunction

  initial begin
    drive("R8 idle word", 32'h0, 32'h0, 3'd7, 5'd0, 1'b0, 1'b1);

    // R1 / R6: I layout across its opcodes and sign edges
    drive("R1 addi max", enc_i(7'b0010011, 3'b000, 12'h7ff), 32'h0000_07ff, 3'd1, 5'd0, 1'b0, 1'b0);
    drive("R6 addi min", enc_i(7'b0010011, 3'b000, 12'h800), 32'hffff_f800, 3'd1, 5'd0, 1'b0, 1'b0);
    drive("R1 load", enc_i(7'b0000011, 3'b010, 12'hffc), 32'hffff_fffc, 3'd1, 5'd0, 1'b0, 1'b0);
    drive("R1 jalr", enc_i(7'b1100111, 3'b000, 12'h123), 32'h0000_0123, 3'd1, 5'd0, 1'b0, 1'b0);

    // R9 / R10: shift-immediate extraction
    drive("R9 slli", enc_i(7'b0010011, 3'b001, 12'h011), 32'h0000_0011, 3'd1, 5'd17, 1'b0, 1'b0);
    drive("R10 slli bit30", enc_i(7'b0010011, 3'b001, 12'h41f), 32'h0000_041f, 3'd1, 5'd31, 1'b0, 1'b0);
    drive("R9 srli", enc_i(7'b0010011, 3'b101, 12'h005), 32'h0000_0005, 3'd1, 5'd5, 1'b0, 1'b0);
    drive("R10 srai", enc_i(7'b0010011, 3'b101, 12'h40a), 32'h0000_040a, 3'd1, 5'd10, 1'b1, 1'b0);
    drive("R10 load f3=101", enc_i(7'b0000011, 3'b101, 12'h405), 32'h0000_0405, 3'd1, 5'd0, 1'b0, 1'b0);
    drive("R9 xori no shamt", enc_i(7'b0010011, 3'b100, 12'h01f), 32'h0000_001f, 3'd1, 5'd0, 1'b0, 1'b0);

    // R2: store
    drive("R2 store -1", enc_s(12'hfff), 32'hffff_ffff, 3'd2, 5'd0, 1'b0, 1'b0);
    drive("R2 store max", enc_s(12'h7e1), 32'h0000_07e1, 3'd2, 5'd0, 1'b0, 1'b0);

    // R3: branch, including the bit-11 path
    drive("R3 branch -2", enc_b(13'h1ffe), 32'hffff_fffe, 3'd3, 5'd0, 1'b0, 1'b0);
    drive("R3 branch max", enc_b(13'h0ffe), 32'h0000_0ffe, 3'd3, 5'd0, 1'b0, 1'b0);
    drive("R3 branch min", enc_b(13'h1000), 32'hffff_f000, 3'd3, 5'd0, 1'b0, 1'b0);
    drive("R3 branch bit11", enc_b(13'h0800), 32'h0000_0800, 3'd3, 5'd0, 1'b0, 1'b0);

    // R4: upper
    drive("R4 lui", enc_u(7'b0110111, 20'hfffff), 32'hffff_f000, 3'd4, 5'd0, 1'b0, 1'b0);
    drive("R4 auipc", enc_u(7'b0010111, 20'h12345), 32'h1234_5000, 3'd4, 5'd0, 1'b0, 1'b0);

    // R5: jump
    drive("R5 jal -2", enc_j(21'h1ffffe), 32'hffff_fffe, 3'd5, 5'd0, 1'b0, 1'b0);
    drive("R5 jal max", enc_j(21'h0ffffe), 32'h000f_fffe, 3'd5, 5'd0, 1'b0, 1'b0);
    drive("R5 jal min", enc_j(21'h100000), 32'hfff0_0000, 3'd5, 5'd0, 1'b0, 1'b0);
    drive("R5 jal bit11", enc_j(21'h000800), 32'h0000_0800, 3'd5, 5'd0, 1'b0, 1'b0);

    // R7: register layout, shift-looking funct3 with bit 30 set
    drive("R7 sra reg", 32'h4000_5033 | 32'hbf_0f80, 32'h0, 3'd0, 5'd0, 1'b0, 1'b0);
    drive("R7 add reg", 32'h0031_0133, 32'h0, 3'd0, 5'd0, 1'b0, 1'b0);

    // R8: unknown opcodes with busy upper bits
    drive("R8 system", 32'hffff_d073, 32'h0, 3'd7, 5'd0, 1'b0, 1'b1);
    drive("R8 fence", 32'hc1f0_500f, 32'h0, 3'd7, 5'd0, 1'b0, 1'b1);
    drive("R8 all ones", 32'hffff_ffff, 32'h0, 3'd7, 5'd0, 1'b0, 1'b1);

    // Sweeps with pseudo-random fields
    for (int k = 0; k < 200; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive("R1 sweep", enc_i(7'b0010011, 3'b110, r[11:0]), sx12(r[11:0]), 3'd1, 5'd0, 1'b0, 1'b0);
      drive("R2 sweep", enc_s(r[23:12]), sx12(r[23:12]), 3'd2, 5'd0, 1'b0, 1'b0);
      drive("R3 sweep", enc_b(r[12:0]), sx13(r[12:0]), 3'd3, 5'd0, 1'b0, 1'b0);
      drive("R4 sweep", enc_u(7'b0010111, r[31:12]), {r[31:12], 12'h000}, 3'd4, 5'd0, 1'b0, 1'b0);
      drive("R5 sweep", enc_j(r[20:0]), sx21(r[20:0]), 3'd5, 5'd0, 1'b0, 1'b0);
      drive("R10 sweep", enc_i(7'b0010011, 3'b101, {1'b0, r[25], 5'b0, r[4:0]}),
            {20'h0, 1'b0, r[25], 5'b0, r[4:0]}, 3'd1, r[4:0], r[25], 1'b0);
    end

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got pending=%0d exp pending=0", q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule